// File: doc/BRIEF.md
# Reverse-Carry Address Update Unit

This block keeps one 16-bit address pointer and moves it forward with reverse-carry addition. The offset is added with the carry running from the most significant bit down to the least significant bit. The carry out of bit 0 is dropped. If the offset is 2^(k-1) and the pointer starts on a base that is a multiple of 2^k, each update visits the next address of a 2^k-entry buffer in bit-reversed order. This is the order needed to fetch FFT twiddle factors or to unscramble FFT results. After 2^k updates the pointer is back on the base, and the bits above bit k-1 never change.

Reverse-carry arithmetic applies only while the modifier input is zero. With any other modifier value, the update strobe leaves the pointer as it is, because other address modes belong to a different unit. A load strobe writes a new pointer value directly and wins over the update strobe. The updated address is also offered combinationally on its own output, so a neighbouring unit can use it in the same cycle.

The pointer register moves through three named transitions each cycle: HOLD keeps its value, LOAD takes the load value, and STEP takes the reverse-carry sum.

Top module: `revcarry_agu`

## Requirements
- R1: While rst_n is low the pointer clears to 0x0000, so `addr` reads 0x0000 at the first sample after reset.
- R2: When `load` is high at a rising clock edge, `addr` equals `load_val` after that edge, whatever `step` and `modifier` are.
- R3: When `step` is high, `load` is low and `modifier` is zero at a rising edge, `addr` afterwards equals the old pointer plus `offset`, with the carry propagating from bit 15 toward bit 0.
- R4: `next_addr` always equals reverse(reverse(`addr`) + reverse(`offset`)) modulo 2^16, where reverse swaps bit i with bit 15-i.
- R5: When `modifier` is non-zero, a `step` without `load` leaves `addr` unchanged.
- R6: With neither `load` nor `step` high, `addr` keeps its value.
- R7: A carry out of bit 0 is discarded. For example, 0x0001 stepped by offset 0x0001 gives 0x0000, and 0xFFFF stepped by 0x8000 gives 0x0000.
- R8: From a base of L*2^k with offset 2^(k-1), successive steps produce the base plus the bit-reversed k-bit count. With k=10 and base 3072 the values are 3072, 3584, 3328, 3840, 3200, 3712. After 2^k steps the pointer equals the base again, and bits 15..k never change along the way.
- R9: An offset of zero leaves the pointer unchanged on a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset, clears the pointer |
| modifier | input | 16 | Mode modifier; zero selects reverse-carry updates |
| load | input | 1 | Writes `load_val` into the pointer |
| load_val | input | 16 | Value to load into the pointer |
| step | input | 1 | Applies one reverse-carry update to the pointer |
| offset | input | 16 | Offset added with reversed carry |
| addr | output | 16 | Current pointer value |
| next_addr | output | 16 | Combinational reverse-carry sum of `addr` and `offset` |

## Verification
The assertions check on every cycle that `next_addr` matches an independent reverse, add and reverse computation. They also check that a load, a step in the zero-modifier mode, a step under a non-zero modifier, and an idle cycle each move the pointer exactly as required. Only the bench's scenarios can show the longer properties. These are the complete bit-reversed walk through a 1024-entry region and its return to the base, agreement with the reference for random pointers at every power-of-two offset, and the reset value.

// File: rtl/revc_pkg.sv
package revc_pkg;

    parameter int AGU_W = 16;

    // Transition taken by the pointer register in a given cycle
    typedef enum logic [1:0] {
        UPD_HOLD = 2'd0,
        UPD_LOAD = 2'd1,
        UPD_STEP = 2'd2
    } upd_e;

endpackage

// File: rtl/revc_adder.sv
module revc_adder #(
    parameter int W = revc_pkg::AGU_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    // c[i+1] is the carry entering bit i; the chain starts at the MSB
    logic [W:0] c;

    assign c[W] = 1'b0;

    generate
        for (genvar i = W - 1; i >= 0; i--) begin : g_stage
            assign sum[i] = a[i] ^ b[i] ^ c[i+1];
            assign c[i]   = (a[i] & b[i]) | (a[i] & c[i+1]) | (b[i] & c[i+1]);
        end
    endgenerate

    // c[0] is the carry out of the LSB and is dropped on purpose
    logic unused_carry;
    assign unused_carry = c[0];

endmodule

// File: rtl/revc_ptr_reg.sv
module revc_ptr_reg #(
    parameter int W = revc_pkg::AGU_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  revc_pkg::upd_e  ctl,
    input  logic [W-1:0]    load_val,
    input  logic [W-1:0]    step_val,
    output logic [W-1:0]    ptr
);
    logic [W-1:0] ptr_d;

    always_comb begin
        unique case (ctl)
            revc_pkg::UPD_LOAD: ptr_d = load_val;
            revc_pkg::UPD_STEP: ptr_d = step_val;
            default:            ptr_d = ptr;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else begin
            ptr <= ptr_d;
        end
    end

endmodule

// File: rtl/revcarry_agu.sv
module revcarry_agu #(
    parameter int AW = revc_pkg::AGU_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] modifier,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    input  logic [AW-1:0] offset,
    output logic [AW-1:0] addr,
    output logic [AW-1:0] next_addr
);
    localparam logic [AW-1:0] REV_SEL = '0;

    revc_pkg::upd_e ctl;
    logic           rev_mode;

    assign rev_mode = (modifier == REV_SEL);

    // Load wins; a step counts only in the reverse-carry mode
    always_comb begin
        if (load) begin
            ctl = revc_pkg::UPD_LOAD;
        end else if (step && rev_mode) begin
            ctl = revc_pkg::UPD_STEP;
        end else begin
            ctl = revc_pkg::UPD_HOLD;
        end
    end

    revc_adder #(.W(AW)) u_adder (
        .a   (addr),
        .b   (offset),
        .sum (next_addr)
    );

    revc_ptr_reg #(.W(AW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl      (ctl),
        .load_val (load_val),
        .step_val (next_addr),
        .ptr      (addr)
    );

endmodule

// File: rtl/revcarry_agu_chk.sv
module revcarry_agu_chk #(
    parameter int AW = revc_pkg::AGU_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] modifier,
    input logic          load,
    input logic [AW-1:0] load_val,
    input logic          step,
    input logic [AW-1:0] offset,
    input logic [AW-1:0] addr,
    input logic [AW-1:0] next_addr
);
    function automatic logic [AW-1:0] flip(input logic [AW-1:0] v);
        logic [AW-1:0] r;
        for (int i = 0; i < AW; i++) begin
            r[i] = v[AW-1-i];
        end
        return r;
    endfunction

    logic [AW-1:0] ref_sum;
    assign ref_sum = flip(flip(addr) + flip(offset));

    // R4
    next_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        next_addr == ref_sum);

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> addr == $past(load_val));

    // R3
    step_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && modifier == '0) |=> addr == $past(ref_sum));

    // R5
    other_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && modifier != '0) |=> $stable(addr));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(addr));

endmodule

bind revcarry_agu revcarry_agu_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .modifier  (modifier),
    .load      (load),
    .load_val  (load_val),
    .step      (step),
    .offset    (offset),
    .addr      (addr),
    .next_addr (next_addr)
);

// File: tb/revcarry_agu_test.sv
module revcarry_agu_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] modifier = '0;
    logic        load = 1'b0;
    logic [15:0] load_val = '0;
    logic        step = 1'b0;
    logic [15:0] offset = '0;
    logic [15:0] addr;
    logic [15:0] next_addr;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    revcarry_agu uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .modifier  (modifier),
        .load      (load),
        .load_val  (load_val),
        .step      (step),
        .offset    (offset),
        .addr      (addr),
        .next_addr (next_addr)
    );

    // {start pointer, offset, expected pointer after one step}
    localparam logic [47:0] VEC [8] = '{
        {16'd3072, 16'd512,  16'd3584},
        {16'h0001, 16'h0001, 16'h0000},
        {16'h0000, 16'h8000, 16'h8000},
        {16'h8000, 16'h8000, 16'h4000},
        {16'h0000, 16'h0001, 16'h0001},
        {16'hFFFF, 16'h8000, 16'h0000},
        {16'h1234, 16'h0000, 16'h1234},
        {16'h00F0, 16'h0010, 16'h00E8}
    };

    function automatic logic [15:0] bench_rev(input logic [15:0] v);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[15-i] = v[i];
        return r;
    endfunction

    function automatic logic [15:0] bench_ref(input logic [15:0] p, input logic [15:0] o);
        return bench_rev(bench_rev(p) + bench_rev(o));
    endfunction

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_load(input logic [15:0] v);
        load = 1'b1; load_val = v;
        tick();
        load = 1'b0;
    endtask

    task automatic do_step(input logic [15:0] o);
        step = 1'b1; offset = o;
        tick();
        step = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] p, up;
        logic        upper_ok;
        repeat (2) @(negedge clk);
        check("R1 reset", addr, 16'h0000);
        rst_n = 1'b1;
        tick();
        check("R1 after release", addr, 16'h0000);

        // Vector table, R3 / R7 / R9
        foreach (VEC[i]) begin
            do_load(VEC[i][47:32]);
            offset = VEC[i][31:16];
            #1;
            check("R4 vec next_addr", next_addr, VEC[i][15:0]);
            do_step(VEC[i][31:16]);
            check("R3 R7 R9 vec step", addr, VEC[i][15:0]);
        end

        // R8 worked sequence, k=10
        do_load(16'd3072);
        check("R8 seq0", addr, 16'd3072);
        do_step(16'd512); check("R8 seq1", addr, 16'd3584);
        do_step(16'd512); check("R8 seq2", addr, 16'd3328);
        do_step(16'd512); check("R8 seq3", addr, 16'd3840);
        do_step(16'd512); check("R8 seq4", addr, 16'd3200);
        do_step(16'd512); check("R8 seq5", addr, 16'd3712);

        // R8 full walk returns to base; upper bits fixed
        do_load(16'd3072);
        upper_ok = 1'b1;
        for (int s = 0; s < 1024; s++) begin
            do_step(16'd512);
            if (addr[15:10] != 6'd3) upper_ok = 1'b0;
        end
        check("R8 wrap to base", addr, 16'd3072);
        check("R8 upper bits fixed", {15'd0, upper_ok}, 16'd1);

        // R3 / R4 random pointers against each power-of-two offset
        for (int b = 0; b < 16; b++) begin
            for (int r = 0; r < 6; r++) begin
                p = 16'($urandom);
                do_load(p);
                offset = 16'h0001 << b;
                #1;
                check("R4 random next_addr", next_addr, bench_ref(p, 16'h0001 << b));
                do_step(16'h0001 << b);
                check("R3 random step", addr, bench_ref(p, 16'h0001 << b));
            end
        end

        // R5 non-zero modifier ignores step
        do_load(16'h0A5C);
        modifier = 16'h001F;
        do_step(16'h0100);
        check("R5 modifier nonzero", addr, 16'h0A5C);
        modifier = 16'hFFFF;
        do_step(16'h8000);
        check("R5 modifier all ones", addr, 16'h0A5C);
        modifier = '0;

        // R6 idle hold
        offset = 16'h4000;
        tick(); tick();
        check("R6 idle hold", addr, 16'h0A5C);

        // R2 load wins over step, also with non-zero modifier
        load = 1'b1; load_val = 16'h7001; step = 1'b1; offset = 16'h8000;
        tick();
        load = 1'b0; step = 1'b0;
        check("R2 load over step", addr, 16'h7001);
        modifier = 16'h0003;
        do_load(16'h1111);
        check("R2 load any modifier", addr, 16'h1111);
        modifier = '0;

        // R1 reset mid-run
        rst_n = 1'b0;
        #1;
        check("R1 async clear", addr, 16'h0000);
        tick();
        rst_n = 1'b1;
        tick();
        check("R1 held after reset", addr, 16'h0000);

        // R3 step right after reset with a value
        up = bench_ref(16'h0000, 16'h0400);
        do_step(16'h0400);
        check("R3 step from zero", addr, up);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule